// File: doc/BRIEF.md
# Cascadable Decimal Ratio Divider

This block divides a slow input clock by a whole decimal number taken from BCD inputs, three digits by default. It is built as a chain of identical one-digit presettable down-counters. Each counter steps down on the rising edges of its own count input and reports zero only when its cascade input allows it. The least significant digit counts the input clock. Each higher digit counts the rising edges of the most significant bit of the digit below it, so it sees one tenth of that digit's rate. The zero flag of each digit feeds the cascade input of the digit below it, so the chain as a whole reports zero only when every digit has reached zero.

The zero flag of the lowest digit is the divider output. It is also fed back as the preset-enable of all digits, so the chain reloads and the cycle repeats every N input clock edges. In a frequency synthesizer this divider scales an oscillator down to the comparison rate, so each unit of N moves the oscillator by one comparison-rate step. Everything runs on one system clock. The input clock is synchronised and edge-detected, and it must stay high for at least two system clocks and low for at least two.

Top module: `bcd_ratio_divider`

## Requirements
- R1: A digit loads its preset when its preset-enable goes from low to high. The first load happens in the first cycle after reset is released, and every later load follows a zero of the chain.
- R2: Each rising edge of a digit's count input lowers its stored value by one, and 0 wraps to 9. With no count edge and no load, the value holds.
- R3: A digit flags zero only while its value is 0 and its cascade input is high. The cascade input of the top digit is tied high, and each lower digit's cascade input is driven by the zero flag of the digit above it.
- R4: `ratioBcd[3:0]` holds the ones digit, `[7:4]` the tens digit and `[11:8]` the hundreds digit. Any code above 9 is loaded as 9.
- R5: A higher digit counts only rising edges of the lower digit's most significant bit that come from counting down. A load never advances it.
- R6: For a ratio N from 10 to 999, `divOut` is a pulse one system clock wide. Successive pulses are exactly N input clock periods apart.
- R7: For a ratio below 10, `outOfRange` is high and `divOut` stays low. A ratio of exactly 10 clears `outOfRange`.
- R8: The ratio present in the system-clock cycle in which `divOut` is high is the one loaded. A change made in the middle of a period does not alter that period.
- R9: During reset `divOut` and `outOfRange` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| inClk | input | 1 | Clock to be divided, sampled on clk |
| ratioBcd | input | 12 | Three BCD digits of the ratio, ones digit lowest |
| divOut | output | 1 | One-cycle pulse every N input clocks |
| outOfRange | output | 1 | High while the ratio is below 10 |

## Verification
A reload of the whole chain and a change of the ratio inputs can land in the same system-clock cycle. In that case the preset captured must be the new one. The bench provokes this by driving a new ratio in the exact cycle in which it sees `divOut` high. It then judges the result by requiring the very next pulse interval to equal the new N times the input clock period. A ratio change made fifty cycles into a period checks the opposite case: that period must keep the old length.

// File: rtl/bcd_div_pkg.sv
package bcd_div_pkg;

  localparam int DIGIT_W = 4;

  typedef struct packed {
    logic presetEn;
    logic outEn;
  } ctrl_t;

  function automatic logic [DIGIT_W-1:0] clampBcd(input logic [DIGIT_W-1:0] code);
    return (code > 4'd9) ? 4'd9 : code;
  endfunction

endpackage

// File: rtl/bcd_div_digit.sv
module bcd_div_digit
  import bcd_div_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               presetEn,
  input  logic [DIGIT_W-1:0] presetBcd,
  input  logic               cntIn,
  input  logic               casIn,
  output logic               zeroOut,
  output logic               tapOut,
  output logic [DIGIT_W-1:0] valOut
);

  logic [DIGIT_W-1:0] val;
  logic pePrev;
  logic cntPrev;
  logic peRise;
  logic cntRise;

  assign peRise  = presetEn && !pePrev;
  assign cntRise = cntIn && !cntPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      val     <= 4'd9;
      pePrev  <= 1'b0;
      cntPrev <= 1'b1;
    end else begin
      pePrev <= presetEn;
      if (peRise) begin
        val     <= clampBcd(presetBcd);
        cntPrev <= 1'b1;
      end else begin
        cntPrev <= cntIn;
        if (cntRise) begin
          val <= (val == 4'd0) ? 4'd9 : val - 4'd1;
        end
      end
    end
  end

  assign zeroOut = casIn && (val == 4'd0);
  assign tapOut  = val[DIGIT_W-1];
  assign valOut  = val;

  // R4: a stored value is always a legal BCD digit
  p_bcd_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    val <= 4'd9);

  // R2: without a count edge or a load the value holds
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cntRise && !peRise) |=> $stable(val));

  // R2: a count edge steps down by one with wrap from 0 to 9
  p_step_down_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cntRise && !peRise) |=>
      (val == (($past(val) == 4'd0) ? 4'd9 : $past(val) - 4'd1)));

endmodule

// File: rtl/bcd_div_datapath.sv
module bcd_div_datapath
  import bcd_div_pkg::*;
#(
  parameter int DIGITS      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inClk,
  input  logic [DIGITS*DIGIT_W-1:0]  ratioBcd,
  input  ctrl_t                      ctrl,
  output logic                       chainZero
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [DIGITS-1:0] digZero;
  logic [DIGITS-1:0] digTap;
  logic [DIGITS-1:0] digCnt;
  logic [DIGITS-1:0] digCas;
  logic [DIGIT_W-1:0] digVal [DIGITS];

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], inClk};
  end

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    if (i == 0) begin : g_low
      assign digCnt[i] = syncQ[SYNC_STAGES-1];
    end else begin : g_up
      assign digCnt[i] = digTap[i-1];
    end

    if (i == DIGITS - 1) begin : g_top
      assign digCas[i] = 1'b1;
    end else begin : g_mid
      assign digCas[i] = digZero[i+1];
    end

    bcd_div_digit u_digit (
      .clk       (clk),
      .rstN      (rstN),
      .presetEn  (ctrl.presetEn),
      .presetBcd (ratioBcd[i*DIGIT_W +: DIGIT_W]),
      .cntIn     (digCnt[i]),
      .casIn     (digCas[i]),
      .zeroOut   (digZero[i]),
      .tapOut    (digTap[i]),
      .valOut    (digVal[i])
    );

    if (i > 0) begin : g_chk
      // R3: the lowest digit flags zero only once every higher digit is zero
      p_low_waits_r3: assert property (@(posedge clk) disable iff (!rstN)
        digZero[0] |-> (digVal[i] == '0));
    end
  end

  assign chainZero = digZero[0];

endmodule

// File: rtl/bcd_div_control.sv
module bcd_div_control
  import bcd_div_pkg::*;
#(
  parameter int DIGITS    = 3,
  parameter int MIN_RATIO = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [DIGITS*DIGIT_W-1:0] ratioBcd,
  input  logic                      chainZero,
  output ctrl_t                     ctrl,
  output logic                      outOfRange
);

  localparam int RATIO_W = DIGITS * DIGIT_W;

  logic startFlag;
  logic rangeLow;
  logic [RATIO_W-1:0] ratioVal;

  always_comb begin
    ratioVal = '0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      ratioVal = ratioVal * RATIO_W'(10)
               + RATIO_W'(clampBcd(ratioBcd[i*DIGIT_W +: DIGIT_W]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startFlag <= 1'b1;
      rangeLow  <= 1'b0;
    end else begin
      startFlag <= 1'b0;
      rangeLow  <= (ratioVal < RATIO_W'(MIN_RATIO));
    end
  end

  assign ctrl.presetEn = chainZero || startFlag;
  assign ctrl.outEn    = !rangeLow;
  assign outOfRange    = rangeLow;

endmodule

// File: rtl/bcd_ratio_divider.sv
module bcd_ratio_divider
  import bcd_div_pkg::*;
#(
  parameter int DIGITS      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RATIO   = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inClk,
  input  logic [DIGITS*DIGIT_W-1:0] ratioBcd,
  output logic                      divOut,
  output logic                      outOfRange
);

  ctrl_t ctrl;
  logic  chainZero;

  bcd_div_control #(
    .DIGITS    (DIGITS),
    .MIN_RATIO (MIN_RATIO)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .ratioBcd   (ratioBcd),
    .chainZero  (chainZero),
    .ctrl       (ctrl),
    .outOfRange (outOfRange)
  );

  bcd_div_datapath #(
    .DIGITS      (DIGITS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .inClk     (inClk),
    .ratioBcd  (ratioBcd),
    .ctrl      (ctrl),
    .chainZero (chainZero)
  );

  assign divOut = chainZero && ctrl.outEn;

  // R6: the output pulse lasts exactly one system clock
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    divOut |=> !divOut);

  // R7: an out-of-range ratio keeps the output quiet
  p_quiet_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    outOfRange |-> !divOut);

endmodule

// File: tb/bcd_ratio_divider_bench.sv
`timescale 1ns/1ps
module bcd_ratio_divider_bench;

  localparam int PER = 4;   // input clock period in system clocks
  localparam int NTAB = 7;
  localparam logic [11:0] RATIO_TAB [NTAB] =
    '{12'h010, 12'h099, 12'h100, 12'h457, 12'h999, 12'h1F5, 12'h0C0};
  localparam int EXP_TAB [NTAB] = '{10, 99, 100, 457, 999, 195, 90};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inClk = 1'b0;
  logic [11:0] ratioBcd = 12'h457;
  logic divOut;
  logic outOfRange;

  int checks = 0;
  int fails = 0;

  bcd_ratio_divider u_bcd_ratio_divider (
    .clk        (clk),
    .rstN       (rstN),
    .inClk      (inClk),
    .ratioBcd   (ratioBcd),
    .divOut     (divOut),
    .outOfRange (outOfRange)
  );

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      repeat (PER/2) @(negedge clk);
      inClk = ~inClk;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // waits for divOut high at a negedge; returns cycles waited or -1
  task automatic waitPulse(input int limit, output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!divOut && cnt < limit);
    if (!divOut) cnt = -1;
  endtask

  initial begin
    int cnt;
    int highs;

    repeat (5) @(negedge clk);
    check(divOut == 1'b0, "R9 divOut in reset", int'(divOut), 0);
    check(outOfRange == 1'b0, "R9 outOfRange in reset", int'(outOfRange), 0);
    rstN = 1'b1;

    // R1: startup load gives a first pulse after about N input clocks
    waitPulse(6000, cnt);
    check(cnt >= 457*PER - 8 && cnt <= 457*PER + 12, "R1 first pulse", cnt, 457*PER);

    // table walk: new ratio driven in the pulse cycle (R8, R6, R2, R3, R5, R4)
    for (int i = 0; i < NTAB; i++) begin
      ratioBcd = RATIO_TAB[i];
      waitPulse(6000, cnt);
      check(cnt == EXP_TAB[i]*PER, "R6 R8 interval (R2 R3 R5 R4)", cnt, EXP_TAB[i]*PER);
    end

    @(negedge clk);
    check(divOut == 1'b0, "R6 pulse width", int'(divOut), 0);

    // R8: mid-period change does not alter the running period
    repeat (49) @(negedge clk);
    ratioBcd = 12'h250;
    waitPulse(6000, cnt);
    check(cnt + 50 == 90*PER, "R8 mid-period change", cnt + 50, 90*PER);
    waitPulse(6000, cnt);
    check(cnt == 250*PER, "R8 new ratio applied", cnt, 250*PER);

    // R7: ratio below 10
    ratioBcd = 12'h005;
    repeat (3) @(negedge clk);
    check(outOfRange == 1'b1, "R7 flag for 5", int'(outOfRange), 1);
    highs = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (divOut) highs++;
    end
    ratioBcd = 12'h009;
    repeat (3) @(negedge clk);
    check(outOfRange == 1'b1, "R7 flag for 9", int'(outOfRange), 1);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (divOut) highs++;
    end
    check(highs == 0, "R7 output quiet", highs, 0);
    ratioBcd = 12'h010;
    repeat (3) @(negedge clk);
    check(outOfRange == 1'b0, "R7 boundary 10", int'(outOfRange), 0);
    waitPulse(6000, cnt);
    check(cnt > 0, "R7 recovery pulse", cnt, 1);
    waitPulse(6000, cnt);
    check(cnt == 10*PER, "R7 recovery interval", cnt, 10*PER);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #750000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule